// File: doc/BRIEF.md
# 160/147 Polyphase Sample Rate Converter

This block turns a mono stream of 16-bit two's complement samples taken at 44.1 kHz into a stream at 48 kHz. The output is defined as follows. Place 159 zeros between each pair of input samples. Filter the result at the 160x rate with a lowpass prototype. Keep one filtered sample out of every 147. The block produces the same numbers without ever forming the zero-stuffed samples, the products that involve them, or the filtered samples that would be thrown away.

A phase register counts modulo 160 and steps by 147 after each output. Its value selects one polyphase branch of the prototype. A single multiply-accumulate unit then walks the `TAPS` coefficients of that branch against the newest inputs in a short history buffer, one tap per cycle. The result is rounded and saturated to 16 bits. Both the input and the output are valid/ready streams. A stalled output holds the phase, and no input is taken while an output is being formed. The prototype coefficients are supplied as a parameter table.

Top module: `src_poly_160_147`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1. The phase and every history entry are 0.
- R2: The first output appears only after exactly `TAPS` input samples have been accepted.
- R3: Output k equals `sum_j h[j]*u[t_k-j]`, where `u[160*m]` is input m and `u` is zero at every other index, `h` is the coefficient table with `TAPS*160` entries, and `t_k = 160*(TAPS-1) + 147*k`.
- R4: Output k uses only the coefficients at addresses `p + 160*i` for i = 0..TAPS-1, where p is the phase. Address offset i multiplies the i-th newest input (i = 0 is the newest). The phase starts at 0 and becomes `(p + 147) mod 160` on each accepted output.
- R5: After an accepted output, exactly one new input is accepted before the next output when `p + 147 >= 160`, and none otherwise. Before output k, exactly `TAPS + floor(147*k/160)` inputs have been accepted in total.
- R6: `in_ready` is 0 whenever `out_valid` is 1 and during the computation of an output.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged and the phase does not move.
- R8: The coefficients are fixed point with `COEF_FRAC` fraction bits. The sum is rounded as `floor((sum + 2^(COEF_FRAC-1)) / 2^COEF_FRAC)`, which rounds halves upward.
- R9: A rounded result above 32767 gives 32767, and one below -32768 gives -32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block takes the offered sample on this edge |
| in_data | input | SAMP_W | Input sample, two's complement |
| out_valid | output | 1 | Output sample available |
| out_ready | input | 1 | Consumer takes the output on this edge |
| out_data | output | SAMP_W | Output sample, two's complement |

## Verification
An accepted output and the wrap decision fall in the same cycle. That single edge advances the phase, releases the output register and decides whether the next branch waits for a new input. The bench provokes this edge by keeping `in_valid` high through long output stalls and releasing `out_ready` in irregular patterns. This way an input is always waiting at the moment of the handshake. Each output is judged on two counts: its value against a zero-stuff, convolve and decimate model, and the total number of inputs accepted so far against `TAPS + floor(147*k/160)`.

// File: rtl/src_pkg.sv
package src_pkg;
  localparam int UP        = 160;
  localparam int DOWN      = 147;
  localparam int TAPS      = 4;
  localparam int SAMP_W    = 16;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;
  localparam int NCOEF     = UP * TAPS;

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef coef_t coef_tab_t [NCOEF];

  // Deterministic scrambled prototype, spread over roughly +/-1.0 in Q(COEF_FRAC).
  function automatic coef_tab_t make_coefs(int seed);
    coef_tab_t tab;
    for (int i = 0; i < NCOEF; i++) begin
      int v;
      v = (i * 7919 + seed * 104729 + 13) % 32749;
      tab[i] = coef_t'(v - 16374);
    end
    return tab;
  endfunction
endpackage

// File: rtl/src_coef_rom.sv
module src_coef_rom #(
  parameter int ADDR_W = 10,
  parameter src_pkg::coef_tab_t COEFS = src_pkg::make_coefs(1)
) (
  input  logic                 clk,
  input  logic [ADDR_W-1:0]    addr,
  output src_pkg::coef_t       coef_q
);
  always_ff @(posedge clk) begin
    coef_q <= COEFS[addr];
  end
endmodule

// File: rtl/src_hist.sv
module src_hist #(
  parameter int TAPS   = 4,
  parameter int SAMP_W = 16,
  localparam int IDX_W = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift,
  input  logic signed [SAMP_W-1:0] din,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic signed [SAMP_W-1:0] rd_q
);
  logic signed [SAMP_W-1:0] line [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) line[i] <= '0;
    end else if (shift) begin
      line[0] <= din;
      for (int i = 1; i < TAPS; i++) line[i] <= line[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= line[rd_idx];
  end
endmodule

// File: rtl/src_mac.sv
module src_mac #(
  parameter int SAMP_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 35,
  localparam int PROD_W = SAMP_W + COEF_W,
  localparam int EXT_W  = ACC_W - PROD_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     en,
  input  logic signed [SAMP_W-1:0] smp,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [ACC_W-1:0]  acc
);
  logic signed [PROD_W-1:0] prod;
  assign prod = smp * coef;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc + {{EXT_W{prod[PROD_W-1]}}, prod};
  end
endmodule

// File: rtl/src_round_sat.sv
module src_round_sat #(
  parameter int ACC_W  = 35,
  parameter int FRAC   = 14,
  parameter int SAMP_W = 16
) (
  input  logic signed [ACC_W-1:0]  acc,
  output logic signed [SAMP_W-1:0] dout
);
  localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'(2**(SAMP_W-1) - 1);
  localparam logic signed [ACC_W:0] MINV = ~MAXV;
  localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(2**(FRAC-1));

  logic signed [ACC_W:0] rnd, shifted;

  always_comb begin
    rnd     = $signed({acc[ACC_W-1], acc}) + HALF;
    shifted = rnd >>> FRAC;
    if (shifted > MAXV)      dout = MAXV[SAMP_W-1:0];
    else if (shifted < MINV) dout = MINV[SAMP_W-1:0];
    else                     dout = shifted[SAMP_W-1:0];
  end
endmodule

// File: rtl/src_poly_160_147.sv
module src_poly_160_147 #(
  parameter int UP        = src_pkg::UP,
  parameter int DOWN      = src_pkg::DOWN,
  parameter int TAPS      = src_pkg::TAPS,
  parameter int SAMP_W    = src_pkg::SAMP_W,
  parameter int COEF_W    = src_pkg::COEF_W,
  parameter int COEF_FRAC = src_pkg::COEF_FRAC,
  parameter src_pkg::coef_tab_t COEFS = src_pkg::make_coefs(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SAMP_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SAMP_W-1:0] out_data
);
  localparam int PH_W   = $clog2(UP);
  localparam int TAP_W  = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int ADDR_W = $clog2(UP * TAPS);
  localparam int ACC_W  = SAMP_W + COEF_W + $clog2(TAPS) + 1;

  typedef enum logic [2:0] {S_FILL, S_MAC, S_LAST, S_RND, S_OUT, S_WAIT} state_t;

  state_t                   state;
  logic [PH_W-1:0]          phase;
  logic [TAP_W-1:0]         tap, fill_cnt;
  logic                     vld_q;
  logic [ADDR_W-1:0]        rom_addr;
  src_pkg::coef_t           coef_q;
  logic signed [SAMP_W-1:0] smp_q, sat_out;
  logic signed [ACC_W-1:0]  acc;
  logic [PH_W:0]            ph_sum;
  logic                     ph_wrap, take_in, acc_clr;

  assign in_ready = (state == S_FILL) || (state == S_WAIT);
  assign take_in  = in_valid && in_ready;
  assign ph_sum   = {1'b0, phase} + (PH_W+1)'(DOWN);
  assign ph_wrap  = ph_sum >= (PH_W+1)'(UP);
  assign rom_addr = ADDR_W'(int'(phase) + UP * int'(tap));
  assign acc_clr  = !((state == S_MAC) || (state == S_LAST));

  src_coef_rom #(.ADDR_W(ADDR_W), .COEFS(COEFS)) u_rom (
    .clk(clk), .addr(rom_addr), .coef_q(coef_q)
  );

  src_hist #(.TAPS(TAPS), .SAMP_W(SAMP_W)) u_hist (
    .clk(clk), .rst(rst), .shift(take_in), .din(in_data),
    .rd_idx(tap), .rd_q(smp_q)
  );

  src_mac #(.SAMP_W(SAMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .clr(acc_clr), .en(vld_q),
    .smp(smp_q), .coef(coef_q), .acc(acc)
  );

  src_round_sat #(.ACC_W(ACC_W), .FRAC(COEF_FRAC), .SAMP_W(SAMP_W)) u_rs (
    .acc(acc), .dout(sat_out)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= (state == S_MAC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_FILL;
      phase     <= '0;
      tap       <= '0;
      fill_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      case (state)
        S_FILL: if (in_valid) begin
          if (fill_cnt == TAP_W'(TAPS - 1)) begin
            state <= S_MAC;
            tap   <= '0;
          end else begin
            fill_cnt <= fill_cnt + 1'b1;
          end
        end
        S_MAC: begin
          if (tap == TAP_W'(TAPS - 1)) state <= S_LAST;
          else                         tap   <= tap + 1'b1;
        end
        S_LAST: state <= S_RND;
        S_RND: begin
          out_data  <= sat_out;
          out_valid <= 1'b1;
          state     <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          tap       <= '0;
          if (ph_wrap) begin
            phase <= PH_W'(ph_sum - (PH_W+1)'(UP));
            state <= S_WAIT;
          end else begin
            phase <= ph_sum[PH_W-1:0];
            state <= S_MAC;
          end
        end
        S_WAIT: if (in_valid) begin
          state <= S_MAC;
          tap   <= '0;
        end
        default: state <= S_FILL;
      endcase
    end
  end
endmodule

// File: rtl/src_poly_checker.sv
module src_poly_checker #(
  parameter int UP   = 160,
  parameter int DOWN = 147,
  parameter int PH_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [15:0]     out_data,
  input logic [PH_W-1:0] phase
);
  logic       started;
  logic [1:0] ins_since_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      started       <= 1'b0;
      ins_since_out <= '0;
    end else if (out_valid && out_ready) begin
      started       <= 1'b1;
      ins_since_out <= '0;
    end else if (in_valid && in_ready && ins_since_out != 2'd3) begin
      ins_since_out <= ins_since_out + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && started)
      AST_ONE_IN_PER_OUT: assert (ins_since_out <= 2'd1) else $error("more than one input between outputs"); // R5
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_ready) |=> $stable(phase)); // R7

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> phase == PH_W'((int'($past(phase)) + DOWN) % UP)); // R4

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(phase) < UP); // R4

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R6

  AST_WRAP_TAKES_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && (int'(phase) + DOWN >= UP) |=> in_ready); // R5

  AST_NOWRAP_SKIPS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && (int'(phase) + DOWN < UP) |=> !in_ready); // R5
endmodule

bind src_poly_160_147 src_poly_checker #(.UP(UP), .DOWN(DOWN), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .phase(phase)
);

// File: tb/src_poly_160_147_tb.sv
module src_poly_160_147_tb;
  import src_pkg::*;

  localparam int NIN = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  always #4 clk = ~clk;

  src_poly_160_147 u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  coef_tab_t   h = make_coefs(1);
  logic signed [15:0] xin [NIN];
  int exp_q[$];
  int need_q[$];
  bit sat_q[$];
  int checks = 0, fails = 0, nout = 0;
  bit finished = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Zero-stuff by UP, convolve with the full prototype, keep every DOWN-th.
  function automatic int ref_out(int k, output bit sat);
    longint t, s, r;
    t = longint'(UP * (TAPS - 1)) + longint'(DOWN) * k;
    s = 0;
    for (int j = 0; j < NCOEF; j++) begin
      longint u;
      u = t - j;
      if (u >= 0 && (u % UP) == 0 && (u / UP) < NIN)
        s += longint'(h[j]) * longint'(xin[int'(u / UP)]);
    end
    r = (s + (longint'(1) << (COEF_FRAC - 1))) >>> COEF_FRAC;
    sat = 1'b0;
    if (r > 32767)  begin r = 32767;  sat = 1'b1; end
    if (r < -32768) begin r = -32768; sat = 1'b1; end
    return int'(r);
  endfunction

  task automatic push_expected();
    int k = 0;
    while (TAPS + (DOWN * k) / UP <= NIN) begin
      bit s;
      int v;
      v = ref_out(k, s);
      exp_q.push_back(v);
      sat_q.push_back(s);
      need_q.push_back(TAPS + (DOWN * k) / UP);
      k++;
    end
    nout = k;
  endtask

  task automatic drive_inputs();
    int idx = 0;
    int cyc = 0;
    while (idx < NIN) begin
      @(negedge clk);
      in_valid = (cyc % 7) != 3;
      in_data  = xin[idx];
      cyc++;
      #1;
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic monitor();
    int popped = 0, in_cnt = 0, cyc = 0;
    bit prev_stall = 1'b0;
    logic [15:0] prev_data = '0;
    while (popped < nout) begin
      @(negedge clk);
      out_ready = ((cyc % 5) != 1) && !(popped >= 40 && popped < 46 && (cyc % 4) != 0);
      cyc++;
      #2;
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R7 held output", int'($signed(out_data)), int'($signed(prev_data)));
      if (out_valid)
        check(!in_ready, "R6 in_ready low with pending output", int'(in_ready), 0);
      if (in_valid && in_ready) in_cnt++;
      if (out_valid && out_ready) begin
        int e, n;
        bit s;
        e = exp_q.pop_front();
        n = need_q.pop_front();
        s = sat_q.pop_front();
        if (s) check(int'($signed(out_data)) == e, "R9 saturated output", int'($signed(out_data)), e);
        else   check(int'($signed(out_data)) == e, "R3 R4 R8 output value", int'($signed(out_data)), e);
        if (popped == 0) check(in_cnt == n, "R2 inputs before first output", in_cnt, n);
        else             check(in_cnt == n, "R5 inputs consumed so far", in_cnt, n);
        popped++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  endtask

  initial begin
    for (int i = 0; i < NIN; i++) begin
      if (i < 70)       xin[i] = 16'(((i * 1103 + 7) % 2001) - 1000);
      else if (i < 140) xin[i] = (((i * 37) % 5) < 3) ? 16'sd32767 : -16'sd32768;
      else              xin[i] = (i == 150) ? 16'sd20000 : 16'(((i * 53) % 41) - 20);
    end
    push_expected();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_data == 16'd0, "R1 out_data after reset", int'(out_data), 0);
    fork
      drive_inputs();
      monitor();
    join
    // Input exhausted: no further output may appear (R5).
    out_ready = 1'b1;
    repeat (30) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R5 no output without a new input", int'(out_valid), 0);
    check(in_ready == 1'b1, "R5 waiting for the next input", int'(in_ready), 1);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule